// File: doc/BRIEF.md
# Endpoint Transfer-Done Interrupt Register

This block keeps the per-endpoint transfer-done interrupt flags of a USB device function with four endpoints. Each endpoint has two flags: one for receive done and one for transmit done. The USB engine raises a flag with a one-cycle event pulse. Firmware reads the flags and writes them over a simple register bus: a written 0 clears a flag and a written 1 sets it, so an interrupt can be raised for test purposes. An enable register masks the flags. The masked flags are combined into one registered interrupt line.

Endpoints configured as isochronous never raise flags. The block also tracks a transmit-void condition for each endpoint. The condition is raised when NAK reporting is on and an IN token is answered with NAK because the transmit FIFO is empty. While the condition lasts and NAK reporting stays on, the endpoint's transmit flag cannot be cleared. Firmware ends the condition by clearing the void bit or by turning NAK reporting off. The isochronous setting and the NAK-reporting setting arrive as inputs from the surrounding register map.

Top module: `ep_done_irq`

## Requirements
- R1: After reset the flag register, the enable register and the void register all read 0x00, and `irq` is 0.
- R2: A pulse on `rx_done[i]` sets flag bit 2i+1, and a pulse on `tx_done[i]` sets flag bit 2i. The flag reads 1 in the cycle after the pulse. The flag register is read at address 0.
- R3: Hardware events never clear a flag: a set flag stays set until firmware writes 0 to it.
- R4: A write to address 0 loads every flag bit from `wr_data`: a 0 clears the bit and a 1 sets it.
- R5: If a firmware write of 0 and a hardware event hit the same flag in the same cycle, the flag ends up set.
- R6: While `ep_iso[i]` is 1, `rx_done[i]` and `tx_done[i]` leave the flags of endpoint i unchanged. Events on other endpoints still take effect.
- R7: A pulse on `in_nak_empty[i]` while `nak_rpt_en[i]` is 1 sets void bit i and flag bit 2i. With `nak_rpt_en[i]` at 0 the pulse changes nothing. Void bit i is read at bit i of address 2.
- R8: While void bit i and `nak_rpt_en[i]` are both 1, flag bit 2i stays 1 even after a firmware clear. Once either of the two is 0, a firmware clear of the flag takes effect.
- R9: The flags read their pending state whatever the value of the enable register (address 1).
- R10: `irq` is the OR of the flags ANDed bitwise with the enable register, registered, so it changes one cycle after the flag or enable change.
- R11: A write to address 2 only clears void bits: bit i written 0 clears void i, and a bit written 1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ep_iso | input | 4 | Endpoint i is configured as isochronous |
| nak_rpt_en | input | 4 | NAK reporting is enabled for endpoint i |
| rx_done | input | 4 | Receive-done event pulse for endpoint i |
| tx_done | input | 4 | Transmit-done event pulse for endpoint i |
| in_nak_empty | input | 4 | Pulse: an IN token was answered with NAK because the transmit FIFO is empty |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 flags, 1 enable, 2 void |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, decoded the same way as `wr_addr` |
| rd_data | output | 8 | Read data for `rd_addr`, combinational; address 3 reads 0 |
| irq | output | 1 | Registered interrupt output |

## Verification
Events and writes are registered at the clock edge, so flag and void results show up on `rd_data` one cycle after the stimulus. `irq` adds its own register and follows one cycle after that. The bench drives inputs on the falling edge and samples on the next falling edge. For `irq` it checks both the cycle where the old value must still be held and the following cycle, where the new value must appear. The void-hold and set-versus-clear checks place the write and the event in the same cycle, so the priority is checked exactly at that edge.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;

  typedef enum logic [1:0] {
    SEL_FLAGS  = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_VOID   = 2'd2,
    SEL_RSVD   = 2'd3
  } reg_sel_e;

  function automatic int tx_bit(input int ep);
    return 2 * ep;
  endfunction

  function automatic int rx_bit(input int ep);
    return 2 * ep + 1;
  endfunction

endpackage

// File: rtl/ep_rst_sync.sv
module ep_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;

endmodule

// File: rtl/ep_done_slice.sv
module ep_done_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic ep_iso,
  input  logic nak_rpt_en,
  input  logic rx_evt,
  input  logic tx_evt,
  input  logic nak_evt,
  input  logic flag_we,
  input  logic wr_rx,
  input  logic wr_tx,
  input  logic void_we,
  input  logic wr_void,
  output logic rx_flag,
  output logic tx_flag,
  output logic tx_void
);

  logic rx_q, tx_q, void_q;
  logic rx_n, tx_n, void_n;
  logic rx_ce, tx_ce, void_ce;
  logic rx_set, tx_set, void_set, void_hold;

  // next-state
  always_comb begin
    rx_set    = rx_evt & ~ep_iso;
    tx_set    = tx_evt & ~ep_iso;
    void_set  = nak_evt & nak_rpt_en;
    void_hold = void_q & nak_rpt_en;

    rx_ce   = flag_we | rx_set;
    tx_ce   = flag_we | tx_set | void_set | void_hold;
    void_ce = void_we | void_set;

    rx_n   = (flag_we ? wr_rx : rx_q) | rx_set;
    tx_n   = (flag_we ? wr_tx : tx_q) | tx_set | void_set | void_hold;
    void_n = ((void_we && !wr_void) ? 1'b0 : void_q) | void_set;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= 1'b0;
      tx_q   <= 1'b0;
      void_q <= 1'b0;
    end else begin
      if (rx_ce)   rx_q   <= rx_n;
      if (tx_ce)   tx_q   <= tx_n;
      if (void_ce) void_q <= void_n;
    end
  end

  assign rx_flag = rx_q;
  assign tx_flag = tx_q;
  assign tx_void = void_q;

  // R3
  rx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_q && !flag_we |=> rx_q);

  // R6
  iso_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ep_iso && !flag_we && !rx_q |=> !rx_q);

  // R5
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt && !ep_iso |=> rx_q);

  // R7
  void_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nak_evt && nak_rpt_en |=> (void_q && tx_q));

  // R8
  void_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    void_q && nak_rpt_en |=> tx_q);

endmodule

// File: rtl/ep_irq_merge.sv
module ep_irq_merge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] flags,
  input  logic [W-1:0] enables,
  output logic         irq
);

  logic irq_q;
  logic irq_n;

  always_comb begin
    irq_n = |(flags & enables);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_n;
  end

  assign irq = irq_q;

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags & enables)) |=> irq_q);

  // R10
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flags & enables)) |=> !irq_q);

endmodule

// File: rtl/ep_done_irq.sv
module ep_done_irq
  import ep_irq_pkg::*;
#(
  parameter int NUM_EP = 4,
  localparam int DW = 2 * NUM_EP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] ep_iso,
  input  logic [NUM_EP-1:0] nak_rpt_en,
  input  logic [NUM_EP-1:0] rx_done,
  input  logic [NUM_EP-1:0] tx_done,
  input  logic [NUM_EP-1:0] in_nak_empty,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              irq
);

  logic              rst_n_s;
  logic [DW-1:0]     flags;
  logic [DW-1:0]     en_q;
  logic [DW-1:0]     en_n;
  logic              en_ce;
  logic [NUM_EP-1:0] void_bits;
  logic              flag_we;
  logic              void_we;
  logic              unused_hi;

  ep_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  always_comb begin
    flag_we = wr_en && (reg_sel_e'(wr_addr) == SEL_FLAGS);
    void_we = wr_en && (reg_sel_e'(wr_addr) == SEL_VOID);
    en_ce   = wr_en && (reg_sel_e'(wr_addr) == SEL_ENABLE);
    en_n    = wr_data;
  end

  assign unused_hi = ^wr_data[DW-1:NUM_EP];

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)   en_q <= '0;
    else if (en_ce) en_q <= en_n;
  end

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    ep_done_slice u_slice (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .ep_iso     (ep_iso[g]),
      .nak_rpt_en (nak_rpt_en[g]),
      .rx_evt     (rx_done[g]),
      .tx_evt     (tx_done[g]),
      .nak_evt    (in_nak_empty[g]),
      .flag_we    (flag_we),
      .wr_rx      (wr_data[rx_bit(g)]),
      .wr_tx      (wr_data[tx_bit(g)]),
      .void_we    (void_we),
      .wr_void    (wr_data[g]),
      .rx_flag    (flags[rx_bit(g)]),
      .tx_flag    (flags[tx_bit(g)]),
      .tx_void    (void_bits[g])
    );
  end

  always_comb begin
    unique case (reg_sel_e'(rd_addr))
      SEL_FLAGS:  rd_data = flags;
      SEL_ENABLE: rd_data = en_q;
      SEL_VOID:   rd_data = {{(DW-NUM_EP){1'b0}}, void_bits};
      default:    rd_data = '0;
    endcase
  end

  ep_irq_merge #(.W(DW)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .flags   (flags),
    .enables (en_q),
    .irq     (irq)
  );

endmodule

// File: tb/sim_ep_done_irq.sv
module sim_ep_done_irq;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] ep_iso, nak_rpt_en, rx_done, tx_done, in_nak_empty;
  logic       wr_en;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ep_done_irq u0 (
    .clk(clk), .rst_n(rst_n), .ep_iso(ep_iso), .nak_rpt_en(nak_rpt_en),
    .rx_done(rx_done), .tx_done(tx_done), .in_nak_empty(in_nak_empty),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R1 flags", 2'd0, 8'h00);
    rd_chk("R1 enable", 2'd1, 8'h00);
    rd_chk("R1 void", 2'd2, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_layout();
    rx_done = 4'b0100; step(); rx_done = '0;
    rd_chk("R2 rx2 bit5", 2'd0, 8'h20);
    tx_done = 4'b0001; step(); tx_done = '0;
    rd_chk("R2 tx0 bit0", 2'd0, 8'h21);
    step();
    chk("R9 irq masked while flags pending", {7'd0, irq}, 8'h00);
    rd_chk("R9 flags with enable 0", 2'd0, 8'h21);
    repeat (3) step();
    rd_chk("R3 flags persist", 2'd0, 8'h21);
  endtask

  task automatic t_fw_write();
    wr(2'd0, 8'h00);
    rd_chk("R4 clear all", 2'd0, 8'h00);
    wr(2'd0, 8'h81);
    rd_chk("R4 firmware set", 2'd0, 8'h81);
    wr(2'd0, 8'h01);
    rd_chk("R4 partial clear", 2'd0, 8'h01);
  endtask

  task automatic t_set_wins();
    rx_done = 4'b0010;
    wr(2'd0, 8'h00);
    rx_done = '0;
    rd_chk("R5 set beats clear", 2'd0, 8'h08);
  endtask

  task automatic t_iso();
    wr(2'd0, 8'h00);
    ep_iso = 4'b1000;
    rx_done = 4'b1000; tx_done = 4'b1010; step();
    rx_done = '0; tx_done = '0;
    rd_chk("R6 iso endpoint ignored", 2'd0, 8'h04);
    ep_iso = '0;
  endtask

  task automatic t_void();
    wr(2'd0, 8'h00);
    in_nak_empty = 4'b0100; step(); in_nak_empty = '0;
    rd_chk("R7 no void without nak report", 2'd2, 8'h00);
    rd_chk("R7 no flag without nak report", 2'd0, 8'h00);
    nak_rpt_en = 4'b0100;
    in_nak_empty = 4'b0100; step(); in_nak_empty = '0;
    rd_chk("R7 void set", 2'd2, 8'h04);
    rd_chk("R7 tx flag set", 2'd0, 8'h10);
    wr(2'd0, 8'h00);
    rd_chk("R8 flag held by void", 2'd0, 8'h10);
    wr(2'd2, 8'hFF);
    rd_chk("R11 write one keeps void", 2'd2, 8'h04);
    wr(2'd2, 8'h00);
    rd_chk("R11 void cleared", 2'd2, 8'h00);
    wr(2'd0, 8'h00);
    rd_chk("R8 clear after void cleared", 2'd0, 8'h00);
    in_nak_empty = 4'b0100; step(); in_nak_empty = '0;
    nak_rpt_en = '0;
    wr(2'd0, 8'h00);
    rd_chk("R8 clear after nak report off", 2'd0, 8'h00);
    rd_chk("R8 void kept after nak report off", 2'd2, 8'h04);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_irq();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h08);
    rd_chk("R10 enable readback", 2'd1, 8'h08);
    tx_done = 4'b0010; step(); tx_done = '0;
    step();
    chk("R10 unmasked flag no irq", {7'd0, irq}, 8'h00);
    rx_done = 4'b0010; step(); rx_done = '0;
    rd_chk("R10 flags", 2'd0, 8'h0C);
    chk("R10 irq latency hold", {7'd0, irq}, 8'h00);
    step();
    chk("R10 irq rises", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h04);
    chk("R10 irq fall latency hold", {7'd0, irq}, 8'h01);
    step();
    chk("R10 irq falls", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0;
    ep_iso = '0; nak_rpt_en = '0; rx_done = '0; tx_done = '0; in_nak_empty = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    t_reset();
    t_layout();
    t_fw_write();
    t_set_wins();
    t_iso();
    t_void();
    t_irq();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule